// File: doc/BRIEF.md
# Parallel Translate-and-Index Cache Lookup

The block takes a 32-bit virtual address and answers, one cycle after the request is registered, whether the addressed word sits in a small physically tagged cache. Translation and cache indexing start together. An eight-slot fully associative translation buffer maps the 20-bit virtual page number to a 20-bit physical frame number. At the same time, the cache arrays are read with an index taken from the 12-bit page offset. The frame number that comes out of translation is then compared with the stored line tags. This overlap is sound because the line index and the byte select both lie wholly inside the untranslated page offset. Capacity is therefore grown by adding a second 4 KB way, not by widening the index.

Software, or a walker outside the block, fills the translation buffer through a load port. That port writes the slot named by a round-robin pointer. Lines are placed through a fill port that names the way and the index explicitly. Each response reports one of three outcomes: a cache hit with its data word, a translation miss, or a protection fault raised when the matching entry does not permit the requested access type.

Top module: `xlate_cache_lookup`

## Requirements
- R1: Reset clears every translation valid bit, every cache line valid bit and the load pointer. After reset, all response outputs are 0 and any lookup reports a translation miss.
- R2: The virtual page number is address bits [31:12] and the line index is bits [11:2]. Bits [1:0] select a byte and do not change any response, which always carries the full 32-bit line word.
- R3: A lookup whose page number matches no valid translation entry reports rsp_tlb_miss=1, rsp_hit=0, rsp_fault=0 and rsp_data=0.
- R4: Each translation entry carries a read-allowed bit and a write-allowed bit. A read (req_write=0) needs read-allowed and a write (req_write=1) needs write-allowed. When the matching entry lacks the needed bit, the response is rsp_fault=1, rsp_hit=0, rsp_tlb_miss=0 and rsp_data=0.
- R5: rsp_hit=1 only when the translation hits, the access is permitted, and some way holds a valid line at the index whose tag equals the translated frame number. The data word of that line is then returned. Otherwise rsp_hit=0 and rsp_data=0.
- R6: With two ways, both tags are compared and either way can supply the hit. If both ways match, way 0 wins.
- R7: A request presented in cycle k is registered at the end of cycle k. Its response appears registered at the end of cycle k+1, with rsp_valid=1 for exactly one cycle. While rsp_valid=0, every flag and the data are 0.
- R8: Each translation load writes the slot named by a pointer that starts at 0 and advances by one modulo 8. The ninth load after reset therefore replaces the first entry.
- R9: A line fill writes the tag, data and valid bit at the given way and index. A fill with fill_valid=0 removes the line.
- R10: A translation load or line fill presented in the same cycle as a request is already visible to that request's lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| tlb_ld_en | input | 1 | Load one translation entry at the pointer slot |
| tlb_ld_vpn | input | 20 | Virtual page number to load |
| tlb_ld_pfn | input | 20 | Physical frame number to load |
| tlb_ld_rd | input | 1 | Read-allowed right |
| tlb_ld_wr | input | 1 | Write-allowed right |
| fill_en | input | 1 | Write one cache line |
| fill_way | input | 1 | Way to write |
| fill_index | input | 10 | Line index to write |
| fill_tag | input | 20 | Physical frame tag to store |
| fill_data | input | 32 | Line data word |
| fill_valid | input | 1 | Valid bit to store |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 32 | Hit data word, 0 otherwise |
| rsp_hit | output | 1 | Cache hit |
| rsp_tlb_miss | output | 1 | No valid translation matched |
| rsp_fault | output | 1 | Access type not permitted |

## Verification
A lookup can fall in the same cycle as a translation load or a line fill that changes its outcome. The bench provokes this by driving a request together with a load or fill aimed at the same page or line. It judges the response against a model in which that write has already happened, so a design that reads stale contents gives a miss where a hit is due. The random phase mixes lookups with loads and fills over small pools of pages, indices and frames, so that collisions of this kind and two-way tag contests arise often.

// File: rtl/lk_pkg.sv
package lk_pkg;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;

  // permission test for one access against the two rights bits
  function automatic logic access_ok(input logic may_rd, input logic may_wr,
                                     input acc_kind_e kind);
    return (kind == ACC_WRITE) ? may_wr : may_rd;
  endfunction

  // round-robin successor of a slot number
  function automatic int unsigned rr_next(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/lk_tlb.sv
module lk_tlb #(
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [VPN_W-1:0] ld_vpn,
  input  logic [PFN_W-1:0] ld_pfn,
  input  logic             ld_rd,
  input  logic             ld_wr,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_rd_ok,
  output logic             lk_wr_ok
);
  import lk_pkg::*;

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] rd_q;
  logic [ENTRIES-1:0] wr_q;
  logic [PTR_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] slot_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (ld_en) begin
      valid_q[ptr_q] <= 1'b1;
      ptr_q          <= PTR_W'(rr_next(32'(ptr_q), ENTRIES));
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      vpn_q[ptr_q] <= ld_vpn;
      pfn_q[ptr_q] <= ld_pfn;
      rd_q[ptr_q]  <= ld_rd;
      wr_q[ptr_q]  <= ld_wr;
    end
  end

  // associative search: one comparator per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign slot_match[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
  end

  // lowest-numbered matching slot is reported
  always_comb begin
    lk_hit   = 1'b0;
    lk_pfn   = '0;
    lk_rd_ok = 1'b0;
    lk_wr_ok = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (slot_match[i]) begin
        lk_hit   = 1'b1;
        lk_pfn   = pfn_q[i];
        lk_rd_ok = rd_q[i];
        lk_wr_ok = wr_q[i];
      end
    end
  end

  // R8
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> ptr_q == PTR_W'(rr_next(32'($past(ptr_q)), ENTRIES)));

  // R8
  slot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> valid_q[$past(ptr_q)] && vpn_q[$past(ptr_q)] == $past(ld_vpn));

endmodule

// File: rtl/lk_way.sv
module lk_way #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  cmp_tag,
  output logic              way_hit,
  output logic [DATA_W-1:0] way_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  // array read uses only the untranslated index; tag compare is late
  assign way_hit  = valid_q[rd_idx] && (tag_q[rd_idx] == cmp_tag);
  assign way_data = data_q[rd_idx];

  // R9
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)] == $past(wr_valid)
              && tag_q[$past(wr_idx)] == $past(wr_tag)
              && data_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/xlate_cache_lookup.sv
module xlate_cache_lookup #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_OFF_W = 12,
  parameter int BSEL_W     = 2,
  parameter int PFN_W      = 20,
  parameter int DATA_W     = 32,
  parameter int TLB_SLOTS  = 8,
  parameter int WAYS       = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [ADDR_W-1:0]              req_vaddr,
  input  logic                           req_write,
  input  logic                           tlb_ld_en,
  input  logic [ADDR_W-PAGE_OFF_W-1:0]   tlb_ld_vpn,
  input  logic [PFN_W-1:0]               tlb_ld_pfn,
  input  logic                           tlb_ld_rd,
  input  logic                           tlb_ld_wr,
  input  logic                           fill_en,
  input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0] fill_way,
  input  logic [PAGE_OFF_W-BSEL_W-1:0]   fill_index,
  input  logic [PFN_W-1:0]               fill_tag,
  input  logic [DATA_W-1:0]              fill_data,
  input  logic                           fill_valid,
  output logic                           rsp_valid,
  output logic [DATA_W-1:0]              rsp_data,
  output logic                           rsp_hit,
  output logic                           rsp_tlb_miss,
  output logic                           rsp_fault
);
  import lk_pkg::*;

  localparam int VPN_W = ADDR_W - PAGE_OFF_W;
  localparam int IDX_W = PAGE_OFF_W - BSEL_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  // byte select never reaches the arrays: the full word is returned
  logic unused_bsel;
  assign unused_bsel = ^req_vaddr[BSEL_W-1:0];

  // registered request
  logic             rq_v;
  logic [VPN_W-1:0] rq_vpn;
  logic [IDX_W-1:0] rq_idx;
  acc_kind_e        rq_kind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq_v    <= 1'b0;
      rq_vpn  <= '0;
      rq_idx  <= '0;
      rq_kind <= ACC_READ;
    end else begin
      rq_v    <= req_valid;
      rq_vpn  <= req_vaddr[ADDR_W-1:PAGE_OFF_W];
      rq_idx  <= req_vaddr[PAGE_OFF_W-1:BSEL_W];
      rq_kind <= acc_kind_e'(req_write);
    end
  end

  // translation, in parallel with the way reads below
  logic             xl_hit;
  logic [PFN_W-1:0] xl_pfn;
  logic             xl_rd_ok;
  logic             xl_wr_ok;

  lk_tlb #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ENTRIES(TLB_SLOTS)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (tlb_ld_en),
    .ld_vpn   (tlb_ld_vpn),
    .ld_pfn   (tlb_ld_pfn),
    .ld_rd    (tlb_ld_rd),
    .ld_wr    (tlb_ld_wr),
    .lk_vpn   (rq_vpn),
    .lk_hit   (xl_hit),
    .lk_pfn   (xl_pfn),
    .lk_rd_ok (xl_rd_ok),
    .lk_wr_ok (xl_wr_ok)
  );

  logic [WAYS-1:0]   way_hit;
  logic [DATA_W-1:0] way_data [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic sel_me;
    if (WAYS > 1) begin : g_multi
      assign sel_me = (fill_way == WAY_W'(w));
    end else begin : g_single
      logic unused_way;
      assign unused_way = fill_way[0];
      assign sel_me     = 1'b1;
    end
    lk_way #(.IDX_W(IDX_W), .TAG_W(PFN_W), .DATA_W(DATA_W)) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (fill_en && sel_me),
      .wr_idx   (fill_index),
      .wr_tag   (fill_tag),
      .wr_data  (fill_data),
      .wr_valid (fill_valid),
      .rd_idx   (rq_idx),
      .cmp_tag  (xl_pfn),
      .way_hit  (way_hit[w]),
      .way_data (way_data[w])
    );
  end

  // lowest way wins a double match
  logic [DATA_W-1:0] pick_data;
  always_comb begin
    pick_data = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (way_hit[i]) pick_data = way_data[i];
    end
  end

  // outcome events, named for the checks below
  logic ev_perm, ev_miss, ev_fault, ev_hit;
  assign ev_perm  = access_ok(xl_rd_ok, xl_wr_ok, rq_kind);
  assign ev_miss  = rq_v && !xl_hit;
  assign ev_fault = rq_v && xl_hit && !ev_perm;
  assign ev_hit   = rq_v && xl_hit && ev_perm && (|way_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_hit      <= 1'b0;
      rsp_tlb_miss <= 1'b0;
      rsp_fault    <= 1'b0;
    end else begin
      rsp_valid    <= rq_v;
      rsp_data     <= ev_hit ? pick_data : '0;
      rsp_hit      <= ev_hit;
      rsp_tlb_miss <= ev_miss;
      rsp_fault    <= ev_fault;
    end
  end

  // R7
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ##2 rsp_valid);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit && !rsp_tlb_miss && !rsp_fault && rsp_data == '0);

  // R5
  hit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid && !rsp_tlb_miss && !rsp_fault);

  // R4
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> !rsp_tlb_miss && !rsp_hit && rsp_data == '0);

  // R3
  miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_tlb_miss |-> !rsp_hit && rsp_data == '0);

endmodule

// File: tb/test_xlate_cache_lookup.sv
module test_xlate_cache_lookup;

  localparam int NWAY  = 2;
  localparam int NSLOT = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_vaddr;
  logic        tlb_ld_en, tlb_ld_rd, tlb_ld_wr;
  logic [19:0] tlb_ld_vpn, tlb_ld_pfn;
  logic        fill_en, fill_valid;
  logic [0:0]  fill_way;
  logic [9:0]  fill_index;
  logic [19:0] fill_tag;
  logic [31:0] fill_data;
  logic        rsp_valid, rsp_hit, rsp_tlb_miss, rsp_fault;
  logic [31:0] rsp_data;

  always #4 clk = ~clk;

  xlate_cache_lookup i_xlate_cache_lookup (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .tlb_ld_en(tlb_ld_en), .tlb_ld_vpn(tlb_ld_vpn), .tlb_ld_pfn(tlb_ld_pfn),
    .tlb_ld_rd(tlb_ld_rd), .tlb_ld_wr(tlb_ld_wr),
    .fill_en(fill_en), .fill_way(fill_way), .fill_index(fill_index),
    .fill_tag(fill_tag), .fill_data(fill_data), .fill_valid(fill_valid),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .rsp_tlb_miss(rsp_tlb_miss), .rsp_fault(rsp_fault)
  );

  int total = 0;
  int bad   = 0;

  // reference state, written from the requirements
  logic        m_tv [NSLOT];
  logic [19:0] m_vpn[NSLOT];
  logic [19:0] m_pfn[NSLOT];
  logic        m_rd [NSLOT];
  logic        m_wr [NSLOT];
  int          m_ptr;
  logic        m_lv [NWAY][1024];
  logic [19:0] m_tag[NWAY][1024];
  logic [31:0] m_dat[NWAY][1024];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < NSLOT; i++) m_tv[i] = 1'b0;
    for (int w = 0; w < NWAY; w++)
      for (int i = 0; i < 1024; i++) m_lv[w][i] = 1'b0;
    m_ptr = 0;
  endfunction

  // expected outcome: {hit, tlb_miss, fault} and data
  function automatic logic [34:0] predict(input logic [31:0] va, input logic wr);
    logic [19:0] vpn = va[31:12];
    logic [9:0]  idx = va[11:2];
    int slot = -1;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (m_tv[i] && m_vpn[i] == vpn) slot = i;
    if (slot < 0) return {3'b010, 32'h0};
    if (wr ? !m_wr[slot] : !m_rd[slot]) return {3'b001, 32'h0};
    for (int w = 0; w < NWAY; w++)
      if (m_lv[w][idx] && m_tag[w][idx] == m_pfn[slot])
        return {3'b100, m_dat[w][idx]};
    return {3'b000, 32'h0};
  endfunction

  task automatic idle_inputs();
    req_valid = 0; req_write = 0; req_vaddr = '0;
    tlb_ld_en = 0; tlb_ld_rd = 0; tlb_ld_wr = 0; tlb_ld_vpn = '0; tlb_ld_pfn = '0;
    fill_en = 0; fill_valid = 0; fill_way = '0; fill_index = '0;
    fill_tag = '0; fill_data = '0;
  endtask

  // all tasks start and end at a falling edge
  task automatic put_tlb(input logic [19:0] vpn, input logic [19:0] pfn,
                         input logic rd, input logic wr);
    tlb_ld_en = 1; tlb_ld_vpn = vpn; tlb_ld_pfn = pfn; tlb_ld_rd = rd; tlb_ld_wr = wr;
    m_tv[m_ptr] = 1; m_vpn[m_ptr] = vpn; m_pfn[m_ptr] = pfn;
    m_rd[m_ptr] = rd; m_wr[m_ptr] = wr;
    m_ptr = (m_ptr + 1) % NSLOT;
  endtask

  task automatic put_fill(input int way, input logic [9:0] idx, input logic [19:0] tag,
                          input logic [31:0] dat, input logic v);
    fill_en = 1; fill_way = 1'(way); fill_index = idx; fill_tag = tag;
    fill_data = dat; fill_valid = v;
    m_lv[way][idx] = v; m_tag[way][idx] = tag; m_dat[way][idx] = dat;
  endtask

  task automatic commit();
    @(negedge clk);
    idle_inputs();
  endtask

  // issue a lookup (with any write already staged), then judge it
  task automatic lookup(input logic [31:0] va, input logic wr, input string req);
    logic [34:0] e;
    req_valid = 1; req_vaddr = va; req_write = wr;
    e = predict(va, wr);
    commit();
    @(negedge clk);
    check(rsp_valid === 1'b1, req, {63'h0, rsp_valid}, 64'h1);
    check({rsp_hit, rsp_tlb_miss, rsp_fault} === e[34:32], req,
          {61'h0, rsp_hit, rsp_tlb_miss, rsp_fault}, {61'h0, e[34:32]});
    check(rsp_data === e[31:0], req, {32'h0, rsp_data}, {32'h0, e[31:0]});
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  bit finished = 0;

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    do_reset();

    // R1: quiet outputs, empty translation buffer
    check({rsp_valid, rsp_hit, rsp_tlb_miss, rsp_fault} === 4'b0 && rsp_data === '0,
          "R1 reset outputs", {59'h0, rsp_valid, rsp_hit, rsp_tlb_miss, rsp_fault, 1'b0}, 64'h0);
    lookup(32'h0000_0000, 0, "R1 miss after reset");
    @(negedge clk);
    check(rsp_valid === 1'b0, "R7 single-cycle valid", {63'h0, rsp_valid}, 64'h0);

    // R3/R5: translation present, line absent, then present
    put_tlb(20'h12345, 20'hABCDE, 1, 1); commit();
    lookup(32'h1234_5010, 0, "R5 tlb hit cache miss");
    put_fill(0, 10'h004, 20'hABCDE, 32'hDEAD_BEEF, 1); commit();
    lookup(32'h1234_5010, 0, "R5 hit way0");
    lookup(32'h9999_9010, 0, "R3 unmapped page");

    // R2: byte select does not matter
    lookup(32'h1234_5013, 0, "R2 byte select 3");
    lookup(32'h1234_5011, 1, "R2 byte select 1 write");

    // R5: wrong frame in tag
    put_fill(0, 10'h005, 20'hABCDF, 32'h1111_2222, 1); commit();
    lookup(32'h1234_5014, 0, "R5 tag mismatch");

    // R6: way 1 holds the line; then both ways match, way 0 wins
    put_fill(1, 10'h006, 20'hABCDE, 32'h6666_0001, 1); commit();
    lookup(32'h1234_5018, 0, "R6 hit way1");
    put_fill(0, 10'h006, 20'hABCDE, 32'h6666_0000, 1); commit();
    lookup(32'h1234_5018, 0, "R6 both ways way0 wins");

    // R9: invalidating fill removes the line
    put_fill(0, 10'h004, 20'hABCDE, 32'h0, 0); commit();
    lookup(32'h1234_5010, 0, "R9 invalidated line");

    // R4: rights
    put_tlb(20'h00777, 20'h00042, 1, 0); commit();
    put_fill(1, 10'h020, 20'h00042, 32'hC0DE_0042, 1); commit();
    lookup(32'h0077_7080, 0, "R4 read permitted");
    lookup(32'h0077_7080, 1, "R4 write denied");
    put_tlb(20'h00888, 20'h00042, 0, 1); commit();
    lookup(32'h0088_8080, 0, "R4 read denied");
    lookup(32'h0088_8080, 1, "R4 write permitted");

    // R10: fill and load in the same cycle as the request
    put_fill(1, 10'h0F0, 20'hABCDE, 32'h5A5A_A5A5, 1);
    lookup(32'h1234_53C0, 0, "R10 same-cycle fill");
    put_tlb(20'h0AAAA, 20'h00042, 1, 1);
    lookup(32'h0AAA_A080, 0, "R10 same-cycle tlb load");

    // R8: fill the remaining slots; the 9th load overwrites slot 0
    for (int k = 0; k < 4; k++) begin
      put_tlb(20'h30000 + 20'(k), 20'h00042, 1, 1); commit();
    end
    put_tlb(20'h0BBBB, 20'h00042, 1, 1); commit();
    lookup(32'h1234_5018, 0, "R8 slot0 replaced");
    lookup(32'h0BBB_B080, 0, "R8 ninth load present");
    lookup(32'h0077_7080, 0, "R8 slot1 kept");

    // random mix over small pools
    for (int it = 0; it < 600; it++) begin
      int op = $urandom % 5;
      logic [19:0] vpn = 20'h40000 + 20'($urandom % 10);
      logic [9:0]  idx = 10'($urandom % 6);
      logic [19:0] pfn = 20'h0F000 + 20'($urandom % 5);
      logic [31:0] va  = {vpn, idx, 2'($urandom % 4)};
      bit dup = 0;
      for (int s = 0; s < NSLOT; s++)
        if (s != m_ptr && m_tv[s] && m_vpn[s] == vpn) dup = 1;
      if (op == 0 && !dup) begin
        put_tlb(vpn, pfn, 1'($urandom % 4 != 0), 1'($urandom % 2)); commit();
      end else if (op == 1) begin
        put_fill(int'($urandom % 2), idx, pfn, $urandom, 1'($urandom % 6 != 0)); commit();
      end else if (op == 2) begin
        put_fill(int'($urandom % 2), idx, pfn, $urandom, 1);
        lookup(va, 1'($urandom % 2), "R10 random same-cycle fill");
      end else begin
        lookup(va, 1'($urandom % 2), "R5 random lookup");
      end
    end

    // R1: reset clears both structures and the pointer
    do_reset();
    lookup(32'h0077_7080, 0, "R1 tlb cleared");
    put_tlb(20'h00777, 20'h00042, 1, 1); commit();
    lookup(32'h0077_7080, 0, "R1 cache cleared");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule